// File: doc/BRIEF.md
# I2C Slave Receiver with General-Call Detection

This block is a receive-only I2C target. It follows SCL and SDA through synchronising flip-flops and recognises START and STOP. The first byte after each START is matched against a 7-bit own address. A general call is flagged separately from an own-address hit, and either one raises a one-cycle interrupt to the host. When the address is neither, the block stays off the bus until the next START or STOP.

After an accepted address it takes data bytes, most significant bit first. In automatic mode every byte is acknowledged at once. In wait mode the block stops after the eighth bit and holds SCL low. The host reads the byte, chooses ACK or NACK, and pulses the release strobe. Each completed ACK is followed by a clock stretch. This gives the host time to collect the byte. A release pulse (the dummy write) ends the stretch and starts the next byte.

The block drives the bus only through two pull-low outputs. These drive open-drain pads, and the wired-AND of each line is fed back on the matching input.

Top module: `i2c_gc_slave`

## Requirements
- R1: After reset both pull-low outputs are 0, both address flags are 0 and the interrupt is 0.
- R2: A first byte whose upper 7 bits equal a non-zero `own_addr_i`, with bit 0 (read/write) equal to 0, sets `addr_hit_o`, clears `gen_call_o` and pulses `irq_o` for one cycle. SDA is pulled low during the ninth clock.
- R3: A first byte of 0x00 sets `gen_call_o`, clears `addr_hit_o`, pulses `irq_o` and is acknowledged. The two flags are never both 1.
- R4: Any other first byte, including the own address with bit 0 equal to 1, clears both flags and raises no interrupt. Neither line is driven before the next START or STOP.
- R5: After each acknowledged address or data byte, SCL is held low from the end of the ninth clock until `release_i` is pulsed.
- R6: In automatic mode (`wait_mode_i`=0) each data byte appears on `rx_data_o` with the first bit received in bit 7. `irq_o` pulses after the eighth bit, and ACK is driven on the ninth clock without host action.
- R7: In wait mode (`wait_mode_i`=1), `irq_o` pulses after the eighth data bit and SCL is held low with SDA released. `ack_val_i` is sampled at the `release_i` pulse: 0 drives ACK (SDA low) and 1 leaves SDA released (NACK) on the ninth clock.
- R8: After a NACK the block does not stretch SCL, raises no interrupt and does not update `rx_data_o` until the next START.
- R9: A STOP returns the block to idle with both lines released. Clocked bytes that follow without a START raise no interrupt and drive nothing.
- R10: A repeated START in any state restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_low_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 pulls SDA low (ACK) |
| own_addr_i | input | ADDR_W | Own 7-bit address |
| wait_mode_i | input | 1 | 1 makes the block wait for the host before each data ACK |
| ack_val_i | input | 1 | Host ACK choice in wait mode: 0 ACK, 1 NACK |
| release_i | input | 1 | One-cycle host strobe: ends a stretch |
| rx_data_o | output | ADDR_W+1 | Last received data byte |
| gen_call_o | output | 1 | Last address byte was a general call |
| addr_hit_o | output | 1 | Last address byte matched the own address |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The address phase is tried with four first bytes: the own address for a write, all zeros, a different address, and the own address for a read. These separate an own-address hit, a general call, and the two forms of mismatch that must leave the bus untouched. Data bytes 0xA5, 0x5C, 0x96 and 0x31 have different bit patterns, so the shift order is visible on the output. Automatic and wait modes are run on the same bus timing, and wait mode is run with both ACK choices. Together these show how the ninth clock is chosen and that a NACK ends the stretching. A repeated START after an ignored address, and bytes clocked after a STOP, test the return to the address phase and to idle.

// File: rtl/i2c_gcs_pkg.sv
package i2c_gcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_ACK    = 3'd2,
      ST_HOLD   = 3'd3,
      ST_DATA   = 3'd4,
      ST_WAIT   = 3'd5,
      ST_IGNORE = 3'd6
   } gcs_state_t;
endpackage

// File: rtl/i2c_gcs_sync.sv
module i2c_gcs_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   for (genvar w = 0; w < WIDTH; w++) begin : g_line
      logic [STAGES-1:0] chain;
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= async_i[w];
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
      assign sync_o[w] = chain[STAGES-1];
   end
endmodule

// File: rtl/i2c_gcs_bus_cond.sv
module i2c_gcs_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign start_o = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o  = scl_s & scl_q & ~sda_q & sda_s;
   assign rise_o  = scl_s & ~scl_q;
   assign fall_o  = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_gcs_shifter.sv
module i2c_gcs_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              sample_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         cnt    <= '0;
      end else if (clr_i) begin
         cnt <= '0;
      end else if (sample_i && cnt != FULL_CNT) begin
         data_o <= {data_o[DATA_W-2:0], bit_i};
         cnt    <= cnt + 1'b1;
      end
   end

   assign full_o = (cnt == FULL_CNT);
endmodule

// File: rtl/i2c_gcs_addr_cmp.sv
module i2c_gcs_addr_cmp #(
   parameter int ADDR_W = 7
) (
   input  logic [ADDR_W:0]   byte_i,
   input  logic [ADDR_W-1:0] own_i,
   output logic              is_gc_o,
   output logic              is_own_o
);
   logic write_dir;
   assign write_dir = ~byte_i[0];
   assign is_gc_o   = write_dir && (byte_i[ADDR_W:1] == '0);
   assign is_own_o  = write_dir && (own_i != '0) && (byte_i[ADDR_W:1] == own_i);
endmodule

// File: rtl/i2c_gcs_ctrl.sv
module i2c_gcs_ctrl
   import i2c_gcs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              full_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              is_gc_i,
   input  logic              is_own_i,
   input  logic              wait_mode_i,
   input  logic              ack_val_i,
   input  logic              release_i,
   output logic              shift_clr_o,
   output logic              shift_en_o,
   output logic              scl_low_o,
   output logic              sda_low_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              gen_call_o,
   output logic              addr_hit_o,
   output logic              irq_o
);
   gcs_state_t state;
   logic       ack_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ack_lo     <= 1'b0;
         gen_call_o <= 1'b0;
         addr_hit_o <= 1'b0;
         irq_o      <= 1'b0;
         rx_data_o  <= '0;
      end else begin
         irq_o <= 1'b0;
         if (start_i) begin
            state  <= ST_ADDR;
            ack_lo <= 1'b0;
         end else if (stop_i) begin
            state  <= ST_IDLE;
            ack_lo <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: if (fall_i && full_i) begin
                  gen_call_o <= is_gc_i;
                  addr_hit_o <= is_own_i;
                  if (is_gc_i || is_own_i) begin
                     irq_o  <= 1'b1;
                     ack_lo <= 1'b1;
                     state  <= ST_ACK;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
               ST_DATA: if (fall_i && full_i) begin
                  rx_data_o <= byte_i;
                  irq_o     <= 1'b1;
                  if (wait_mode_i) begin
                     state <= ST_WAIT;
                  end else begin
                     ack_lo <= 1'b1;
                     state  <= ST_ACK;
                  end
               end
               ST_WAIT: if (release_i) begin
                  ack_lo <= ~ack_val_i;
                  state  <= ST_ACK;
               end
               ST_ACK: if (fall_i) begin
                  ack_lo <= 1'b0;
                  state  <= ack_lo ? ST_HOLD : ST_IGNORE;
               end
               ST_HOLD: if (release_i) begin
                  state <= ST_DATA;
               end
               default: ;
            endcase
         end
      end
   end

   assign shift_clr_o = start_i | ((state == ST_HOLD) & release_i);
   assign shift_en_o  = rise_i & ((state == ST_ADDR) | (state == ST_DATA));
   assign scl_low_o   = (state == ST_HOLD) | (state == ST_WAIT);
   assign sda_low_o   = (state == ST_ACK) & ack_lo;
endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave #(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_low_o,
   output logic              sda_low_o,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              wait_mode_i,
   input  logic              ack_val_i,
   input  logic              release_i,
   output logic [ADDR_W:0]   rx_data_o,
   output logic              gen_call_o,
   output logic              addr_hit_o,
   output logic              irq_o
);
   localparam int DATA_W = ADDR_W + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic [1:0]        line_s;
   logic              start, stop, rise, fall;
   logic              shift_clr, shift_en, full;
   logic [DATA_W-1:0] shift_data;
   logic              is_gc, is_own;

   i2c_gcs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .async_i({scl_i, sda_i}),
      .sync_o(line_s)
   );

   i2c_gcs_bus_cond cond_i (
      .clk(clk), .rst_n(rst_n),
      .scl_s(line_s[1]), .sda_s(line_s[0]),
      .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
   );

   i2c_gcs_shifter #(.DATA_W(DATA_W)) shift_i (
      .clk(clk), .rst_n(rst_n),
      .clr_i(shift_clr), .sample_i(shift_en), .bit_i(line_s[0]),
      .data_o(shift_data), .full_o(full)
   );

   i2c_gcs_addr_cmp #(.ADDR_W(ADDR_W)) cmp_i (
      .byte_i(shift_data), .own_i(own_addr_i),
      .is_gc_o(is_gc), .is_own_o(is_own)
   );

   i2c_gcs_ctrl #(.DATA_W(DATA_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
      .full_i(full), .byte_i(shift_data),
      .is_gc_i(is_gc), .is_own_i(is_own),
      .wait_mode_i(wait_mode_i), .ack_val_i(ack_val_i), .release_i(release_i),
      .shift_clr_o(shift_clr), .shift_en_o(shift_en),
      .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
      .rx_data_o(rx_data_o), .gen_call_o(gen_call_o),
      .addr_hit_o(addr_hit_o), .irq_o(irq_o)
   );
endmodule

// File: rtl/i2c_gc_slave_chk.sv
module i2c_gc_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_low_o,
   input logic sda_low_o,
   input logic release_i,
   input logic gen_call_o,
   input logic addr_hit_o,
   input logic irq_o
);
   p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(gen_call_o && addr_hit_o));

   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   p_irq_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (gen_call_o || addr_hit_o));

   p_quiet_unaddressed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_call_o && !addr_hit_o) |-> (!sda_low_o && !scl_low_o));

   p_stretch_until_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_low_o && !release_i) |=> scl_low_o);

   p_no_joint_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_low_o && sda_low_o));
endmodule

bind i2c_gc_slave i2c_gc_slave_chk chk_i (
   .clk(clk), .rst_n(rst_n),
   .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
   .release_i(release_i),
   .gen_call_o(gen_call_o), .addr_hit_o(addr_hit_o),
   .irq_o(irq_o)
);

// File: tb/i2c_gc_slave_tb_top.sv
module i2c_gc_slave_tb_top;
   localparam int HP = 16;
   localparam logic [6:0] OWN = 7'h3A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic wait_mode = 1'b0, ack_val = 1'b0, release_s = 1'b0;
   logic scl_low, sda_low, gen_call, addr_hit, irq;
   logic [7:0] rx_data;
   logic scl_bus, sda_bus;

   int n_chk = 0, n_fail = 0;
   int irq_n = 0, scl_drv_n = 0, sda_drv_n = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign scl_bus = m_scl & ~scl_low;
   assign sda_bus = m_sda & ~sda_low;

   i2c_gc_slave dut_i (
      .clk(clk), .rst_n(rst_n),
      .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_low_o(scl_low), .sda_low_o(sda_low),
      .own_addr_i(OWN), .wait_mode_i(wait_mode),
      .ack_val_i(ack_val), .release_i(release_s),
      .rx_data_o(rx_data), .gen_call_o(gen_call),
      .addr_hit_o(addr_hit), .irq_o(irq)
   );

   always @(negedge clk) begin
      if (irq)     irq_n++;
      if (scl_low) scl_drv_n++;
      if (sda_low) sda_drv_n++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wcyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scl_high;
      m_scl = 1'b1;
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic start_cond;
      m_sda = 1'b1; wcyc(HP);
      scl_high; wcyc(HP);
      m_sda = 1'b0; wcyc(HP);
      m_scl = 1'b0; wcyc(HP);
   endtask

   task automatic stop_cond;
      m_sda = 1'b0; wcyc(HP);
      scl_high; wcyc(HP);
      m_sda = 1'b1; wcyc(HP);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; wcyc(HP);
      scl_high; wcyc(HP);
      m_scl = 1'b0; wcyc(4);
   endtask

   task automatic send8(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      m_sda = 1'b1;
      wcyc(HP);
   endtask

   task automatic ack_clock(output logic r);
      m_sda = 1'b1; wcyc(HP);
      scl_high; wcyc(HP / 2);
      r = sda_bus;
      wcyc(HP / 2);
      m_scl = 1'b0; wcyc(HP);
   endtask

   task automatic host_release(input logic a);
      ack_val = a;
      release_s = 1'b1;
      @(negedge clk);
      release_s = 1'b0;
      wcyc(2);
   endtask

   task automatic t_reset;
      chk("R1 scl_low", scl_low, 0);
      chk("R1 sda_low", sda_low, 0);
      chk("R1 flags", {gen_call, addr_hit}, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_own_auto;
      int i0;
      logic a;
      wait_mode = 1'b0;
      start_cond;
      i0 = irq_n;
      send8({OWN, 1'b0});
      chk("R2 irq", irq_n - i0, 1);
      chk("R2 flags hit/gc", {addr_hit, gen_call}, 2'b10);
      ack_clock(a);
      chk("R2 ack", a, 0);
      chk("R5 stretch after addr", scl_low, 1);
      wcyc(40);
      chk("R5 still stretched", scl_low, 1);
      host_release(1'b0);
      chk("R5 released", scl_low, 0);
      i0 = irq_n;
      send8(8'hA5);
      chk("R6 irq", irq_n - i0, 1);
      chk("R6 rx A5", rx_data, 8'hA5);
      ack_clock(a);
      chk("R6 auto ack", a, 0);
      chk("R5 stretch after data", scl_low, 1);
      host_release(1'b1);
      send8(8'h5C);
      chk("R6 rx 5C", rx_data, 8'h5C);
      ack_clock(a);
      chk("R6 auto ack ignores ack_val", a, 0);
      host_release(1'b0);
      stop_cond;
      chk("R9 lines free", {scl_low, sda_low}, 0);
   endtask

   task automatic t_after_stop;
      int i0, s0, d0;
      i0 = irq_n; s0 = scl_drv_n; d0 = sda_drv_n;
      m_scl = 1'b0; wcyc(HP);
      send8(8'h3C);
      send8(8'hC3);
      chk("R9 no irq after stop", irq_n - i0, 0);
      chk("R9 no drive after stop", (scl_drv_n - s0) + (sda_drv_n - d0), 0);
      stop_cond;
   endtask

   task automatic t_gen_call;
      int i0;
      logic a;
      start_cond;
      i0 = irq_n;
      send8(8'h00);
      chk("R3 irq", irq_n - i0, 1);
      chk("R3 flags gc/hit", {gen_call, addr_hit}, 2'b10);
      ack_clock(a);
      chk("R3 ack", a, 0);
      host_release(1'b0);
      stop_cond;
   endtask

   task automatic t_mismatch(input logic [7:0] first, input string tag);
      int i0, s0, d0;
      logic a;
      start_cond;
      i0 = irq_n; s0 = scl_drv_n; d0 = sda_drv_n;
      send8(first);
      chk({tag, " flags"}, {gen_call, addr_hit}, 0);
      ack_clock(a);
      chk({tag, " nack"}, a, 1);
      send8(8'hFF);
      ack_clock(a);
      chk({tag, " no irq"}, irq_n - i0, 0);
      chk({tag, " no drive"}, (scl_drv_n - s0) + (sda_drv_n - d0), 0);
      stop_cond;
   endtask

   task automatic t_wait_mode;
      int i0, s0;
      logic a;
      wait_mode = 1'b1;
      start_cond;
      send8({OWN, 1'b0});
      ack_clock(a);
      host_release(1'b0);
      i0 = irq_n;
      send8(8'h96);
      chk("R7 irq before ack", irq_n - i0, 1);
      chk("R7 rx 96", rx_data, 8'h96);
      chk("R7 stretch/sda", {scl_low, sda_low}, 2'b10);
      host_release(1'b0);
      ack_clock(a);
      chk("R7 chosen ack", a, 0);
      host_release(1'b0);
      send8(8'h31);
      host_release(1'b1);
      ack_clock(a);
      chk("R7 chosen nack", a, 1);
      wcyc(20);
      chk("R8 no stretch after nack", scl_low, 0);
      i0 = irq_n; s0 = scl_drv_n;
      send8(8'h77);
      chk("R8 no irq", irq_n - i0, 0);
      chk("R8 rx held", rx_data, 8'h31);
      chk("R8 no stretch", scl_drv_n - s0, 0);
      stop_cond;
      wait_mode = 1'b0;
   endtask

   task automatic t_restart;
      logic a;
      start_cond;
      send8(8'h55);
      chk("R10 ignored first", {gen_call, addr_hit}, 0);
      ack_clock(a);
      start_cond;
      send8({OWN, 1'b0});
      chk("R10 hit after restart", {gen_call, addr_hit}, 2'b01);
      ack_clock(a);
      chk("R10 ack", a, 0);
      host_release(1'b0);
      stop_cond;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      wcyc(5);
      rst_n = 1'b1;
      wcyc(5);
      t_reset;
      t_own_auto;
      t_after_stop;
      t_gen_call;
      t_mismatch(8'h76, "R4 other addr");
      t_mismatch({OWN, 1'b1}, "R4 read dir");
      t_wait_mode;
      t_restart;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule